// File: doc/BRIEF.md
# Board Supply Rail Sequencer

This block is a clocked supervisor that brings up and takes down the supply rails of a board that all draw from one upstream intermediate bus. It watches an enable for the upstream supply, a comparator flag that says the bus is above its undervoltage threshold, the power-good flags of six main converters and one late converter, and a single good flag for the secondary linear rails. From these it drives one enable shared by the six main converters, a ramp-release line that lets those converters' outputs rise together, an enable for the late converter, and the active-low board reset.

Power-up is a timed chain. The bus settles first. The main converters are then enabled while their ramp is held back. The ramp is released, and the late converter starts a fixed time after all six main rails are good. The board reset is released a fixed time after every rail is good. A drop of the upstream enable or a bus sag at any point after the settle phase starts an orderly shutdown. If the main rails never come good, the block locks into a fault state. Every delay is derived from a clock-frequency parameter. All asynchronous inputs pass through two-flop synchronizers, and the bus flag is also debounced.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, and while the upstream enable is low, all three enables are low and `brd_rst_n` is low.
- R2: Power-up starts only when `up_en` is high and `bus_ok` is high (1 = bus above threshold). With `bus_ok` low, nothing is enabled.
- R3: After the start condition, `main_en` stays low for SETTLE_MS (500 ms) and then rises.
- R4: `main_en` drives all six main converters together while `late_en` stays low. `ramp_go` stays low for HOLD_MS (120 ms) after `main_en` rises and then goes high.
- R5: `late_en` rises LATE_MS (100 ms) after all six bits of `main_pg` are high.
- R6: `brd_rst_n` goes high RSTREL_MS (500 ms) after all of `main_pg`, `late_pg` and `lin_ok` are high.
- R7: When `up_en` drops after the main rails are running, `late_en` and `ramp_go` fall and `brd_rst_n` goes low within a few cycles. `main_en` stays high while the bus is good until every main power-good has fallen.
- R8: When the debounced bus flag goes low during or after power-up, all enables drop and `brd_rst_n` is low.
- R9: If `main_pg` is not all high within TMO_MS (50 ms) of ramp release, every output goes low. They stay low while `up_en` stays high. Only a low `up_en` lets a new power-up start.
- R10: An enable drop or bus loss during a power-up waiting phase aborts the sequence. A later start repeats the full settle delay.
- R11: A low pulse on `bus_ok` shorter than FILT_LEN clock cycles has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_en | input | 1 | Upstream supply enable (async) |
| bus_ok | input | 1 | Bus above undervoltage threshold (async) |
| main_pg | input | 6 | Power-good of the six main converters (async) |
| late_pg | input | 1 | Power-good of the late converter (async) |
| lin_ok | input | 1 | Secondary linear rails good (async) |
| main_en | output | 1 | Shared enable of the main converters |
| ramp_go | output | 1 | Ramp release to the main converters |
| late_en | output | 1 | Enable of the late converter |
| brd_rst_n | output | 1 | Active-low board reset |

## Verification
The bench builds the block with CLK_HZ set to 2000, so each millisecond is two cycles. The 500 ms settle and reset-release waits become 1000 cycles, and the 50 ms timeout becomes 100 cycles. This puts the whole power-up chain, the fault lock-out and several shutdown runs within a few thousand cycles. Each delay is checked on both sides of its edge, with margins tight enough to catch an off-by-scale delay. FILT_LEN stays at 4, so a two-cycle bus glitch falls below the debounce window.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_OFF,
    ST_SETTLE,
    ST_HOLD,
    ST_RAMP,
    ST_LATE_WAIT,
    ST_LATE_ON,
    ST_RST_HOLD,
    ST_RUN,
    ST_SHUT,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pwr_filt.sv
module pwr_filt #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          val_q, val_d;

  always_comb begin
    cnt_d = '0;
    val_d = val_q;
    if (d != val_q) begin
      if (cnt_q == CW'(LEN - 1)) begin
        val_d = d;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

  assign q = val_q;
endmodule

// File: rtl/pwr_timer.sv
module pwr_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned N_MAIN    = 6,
  parameter int unsigned FILT_LEN  = 4,
  parameter int unsigned SETTLE_MS = 500,
  parameter int unsigned HOLD_MS   = 120,
  parameter int unsigned LATE_MS   = 100,
  parameter int unsigned RSTREL_MS = 500,
  parameter int unsigned TMO_MS    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_en,
  input  logic              bus_ok,
  input  logic [N_MAIN-1:0] main_pg,
  input  logic              late_pg,
  input  logic              lin_ok,
  output logic              main_en,
  output logic              ramp_go,
  output logic              late_en,
  output logic              brd_rst_n
);
  import pwr_seq_pkg::*;

  localparam int unsigned CYC_MS     = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int unsigned SETTLE_CYC = SETTLE_MS * CYC_MS;
  localparam int unsigned HOLD_CYC   = HOLD_MS * CYC_MS;
  localparam int unsigned LATE_CYC   = LATE_MS * CYC_MS;
  localparam int unsigned RSTREL_CYC = RSTREL_MS * CYC_MS;
  localparam int unsigned TMO_CYC    = TMO_MS * CYC_MS;
  localparam int unsigned MAX_A      = (SETTLE_CYC > RSTREL_CYC) ? SETTLE_CYC : RSTREL_CYC;
  localparam int unsigned MAX_B      = (HOLD_CYC > LATE_CYC) ? HOLD_CYC : LATE_CYC;
  localparam int unsigned MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC    = (MAX_C > TMO_CYC) ? MAX_C : TMO_CYC;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);
  localparam int unsigned SW         = N_MAIN + 4;

  logic [SW-1:0]     raw_v, sync_v;
  logic              en_s, bus_raw_s, bus_s, late_s, lin_s;
  logic [N_MAIN-1:0] main_s;
  logic              all_main, all_good, abort;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  seq_state_e        st_q, st_d;

  assign raw_v = {up_en, bus_ok, late_pg, lin_ok, main_pg};

  pwr_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(sync_v)
  );

  assign en_s      = sync_v[SW-1];
  assign bus_raw_s = sync_v[SW-2];
  assign late_s    = sync_v[SW-3];
  assign lin_s     = sync_v[SW-4];
  assign main_s    = sync_v[N_MAIN-1:0];

  pwr_filt #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(bus_raw_s), .q(bus_s)
  );

  assign all_main = &main_s;
  assign all_good = all_main && late_s && lin_s;
  assign abort    = !en_s || !bus_s;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:       if (en_s && bus_s) st_d = ST_SETTLE;
      ST_SETTLE:    if (abort) st_d = ST_OFF;
                    else if (tmr_done) st_d = ST_HOLD;
      ST_HOLD:      if (abort) st_d = ST_SHUT;
                    else if (tmr_done) st_d = ST_RAMP;
      ST_RAMP:      if (abort) st_d = ST_SHUT;
                    else if (all_main) st_d = ST_LATE_WAIT;
                    else if (tmr_done) st_d = ST_FAULT;
      ST_LATE_WAIT: if (abort) st_d = ST_SHUT;
                    else if (tmr_done) st_d = ST_LATE_ON;
      ST_LATE_ON:   if (abort) st_d = ST_SHUT;
                    else if (all_good) st_d = ST_RST_HOLD;
      ST_RST_HOLD:  if (abort) st_d = ST_SHUT;
                    else if (tmr_done) st_d = ST_RUN;
      ST_RUN:       if (abort) st_d = ST_SHUT;
      ST_SHUT:      if (!bus_s || (main_s == '0)) st_d = ST_OFF;
      ST_FAULT:     if (!en_s) st_d = ST_OFF;
      default:      st_d = ST_OFF;
    endcase
  end

  // timer reload on every state entry
  assign tmr_load = (st_d != st_q);

  always_comb begin
    unique case (st_d)
      ST_SETTLE:    tmr_val = TW'(SETTLE_CYC - 1);
      ST_HOLD:      tmr_val = TW'(HOLD_CYC - 1);
      ST_RAMP:      tmr_val = TW'(TMO_CYC - 1);
      ST_LATE_WAIT: tmr_val = TW'(LATE_CYC - 1);
      ST_RST_HOLD:  tmr_val = TW'(RSTREL_CYC - 1);
      default:      tmr_val = '0;
    endcase
  end

  pwr_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // outputs decoded from state
  always_comb begin
    main_en   = 1'b0;
    ramp_go   = 1'b0;
    late_en   = 1'b0;
    brd_rst_n = 1'b0;
    unique case (st_q)
      ST_HOLD:      main_en = 1'b1;
      ST_RAMP,
      ST_LATE_WAIT: begin main_en = 1'b1; ramp_go = 1'b1; end
      ST_LATE_ON,
      ST_RST_HOLD:  begin main_en = 1'b1; ramp_go = 1'b1; late_en = 1'b1; end
      ST_RUN:       begin main_en = 1'b1; ramp_go = 1'b1; late_en = 1'b1; brd_rst_n = 1'b1; end
      ST_SHUT:      main_en = bus_s;
      default:      ;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic main_en,
  input logic ramp_go,
  input logic late_en,
  input logic brd_rst_n
);
  // R4: ramp release never without the main enable
  p_ramp_needs_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_go |-> main_en);

  // R4: main enable rises with ramp held and late converter off
  p_main_rise_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> (!ramp_go && !late_en));

  // R5: late converter only starts on released main rails
  p_late_after_ramp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_en) |-> (ramp_go && main_en));

  // R6: board out of reset only with every enable active
  p_rst_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brd_rst_n |-> (main_en && ramp_go && late_en));

  // R7: withdrawing the ramp also kills the late converter and holds reset
  p_ramp_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_go) |-> (!late_en && !brd_rst_n));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_en(main_en), .ramp_go(ramp_go),
  .late_en(late_en), .brd_rst_n(brd_rst_n)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_en, bus_ok, late_pg, lin_ok;
  logic [5:0] main_pg;
  logic       main_en, ramp_go, late_en, brd_rst_n;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.CLK_HZ(2000)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_en(up_en), .bus_ok(bus_ok),
    .main_pg(main_pg), .late_pg(late_pg), .lin_ok(lin_ok),
    .main_en(main_en), .ramp_go(ramp_go), .late_en(late_en), .brd_rst_n(brd_rst_n)
  );

  // vector: {en, bus, pg[5:0], late, lin, wait[15:0], exp{main,ramp,late,rst}}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b0, 16'd990,  4'b0000},
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b0, 16'd30,   4'b1000},
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b0, 16'd220,  4'b1000},
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b0, 16'd20,   4'b1100},
    {1'b1, 1'b1, 6'h3F, 1'b0, 1'b0, 16'd190,  4'b1100},
    {1'b1, 1'b1, 6'h3F, 1'b0, 1'b0, 16'd20,   4'b1110},
    {1'b1, 1'b1, 6'h3F, 1'b1, 1'b1, 16'd990,  4'b1110},
    {1'b1, 1'b1, 6'h3F, 1'b1, 1'b1, 16'd20,   4'b1111}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {main_en, ramp_go, late_en, brd_rst_n};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {main,ramp,late,rst_n} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic en, input logic bus, input logic [5:0] pg,
                       input logic lp, input logic lo);
    up_en = en; bus_ok = bus; main_pg = pg; late_pg = lp; lin_ok = lo;
  endtask

  task automatic bring_up();
    drive(1, 1, 6'h00, 0, 0);
    wait_n(1280);
    main_pg = 6'h3F;
    wait_n(220);
    late_pg = 1'b1; lin_ok = 1'b1;
    wait_n(1030);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 1, 6'h00, 0, 0);
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 reset state", 4'b0000);
    wait_n(100);
    check("R1 idle with enable low", 4'b0000);

    // R2: enable high but bus below threshold
    drive(1, 0, 6'h00, 0, 0);
    wait_n(1500);
    check("R2 no start without bus", 4'b0000);
    drive(0, 1, 6'h00, 0, 0);
    wait_n(10);

    // table walk: nominal power-up (R3..R6)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28], VEC[i][27:22], VEC[i][21], VEC[i][20]);
      wait_n(int'(VEC[i][19:4]));
      case (i)
        0, 1:    check("R3 settle delay", VEC[i][3:0]);
        2, 3:    check("R4 ramp hold", VEC[i][3:0]);
        4, 5:    check("R5 late converter delay", VEC[i][3:0]);
        default: check("R6 reset release delay", VEC[i][3:0]);
      endcase
    end

    // R11: short bus glitch ignored
    bus_ok = 1'b0;
    wait_n(2);
    bus_ok = 1'b1;
    wait_n(20);
    check("R11 bus glitch ignored", 4'b1111);

    // R7: enable drop in run
    up_en = 1'b0;
    wait_n(6);
    check("R7 late off, reset on, main held", 4'b1000);
    main_pg = 6'h00; late_pg = 1'b0; lin_ok = 1'b0;
    wait_n(6);
    check("R7 main off after rails down", 4'b0000);
    wait_n(10);

    // R8: bus sag in run
    bring_up();
    check("R6 second bring-up", 4'b1111);
    bus_ok = 1'b0;
    wait_n(10);
    check("R8 bus sag drops all", 4'b0000);
    drive(0, 1, 6'h00, 0, 0);
    wait_n(10);

    // R10: abort in hold phase
    drive(1, 1, 6'h00, 0, 0);
    wait_n(1100);
    check("R10 in hold phase", 4'b1000);
    up_en = 1'b0;
    wait_n(6);
    check("R10 abort from hold", 4'b0000);
    wait_n(10);

    // R10: abort in settle phase restarts the full settle
    up_en = 1'b1;
    wait_n(500);
    bus_ok = 1'b0;
    wait_n(20);
    bus_ok = 1'b1;
    wait_n(800);
    check("R10 settle restarted", 4'b0000);
    wait_n(220);
    check("R10 enable after restarted settle", 4'b1000);
    drive(0, 1, 6'h00, 0, 0);
    wait_n(10);

    // R9: power-good timeout
    drive(1, 1, 6'h00, 0, 0);
    wait_n(1280);
    check("R9 ramp released", 4'b1100);
    wait_n(40);
    check("R9 before timeout", 4'b1100);
    wait_n(50);
    check("R9 fault after timeout", 4'b0000);
    wait_n(2000);
    check("R9 fault held with enable high", 4'b0000);
    up_en = 1'b0;
    wait_n(10);
    up_en = 1'b1;
    wait_n(1030);
    check("R9 restart after enable cycle", 4'b1000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule